// File: doc/BRIEF.md
# SPI Register Access Frame Decoder

This block is the slave end of a word-addressed register access link carried over SPI in mode 0. Every transfer framed by chip select opens with a 32-bit command word, sent most significant bit first. The command word holds an access direction, a word address and, for reads, the number of words to return. On a write, each complete 32-bit word that follows the command word is stored into a register file at consecutive word addresses. On a read, the requested words come back on MISO in the same full-duplex transfer, starting on the bit right after the command word.

The SPI pins are brought into the system clock domain through two-flop synchronizers and sampled by edge detection. SCLK therefore has to be slow compared with the system clock: each SCLK high phase and each low phase must last at least six system clock cycles. The register-file side is a plain synchronous port. A write is a one-cycle `rf_we` pulse with `rf_addr` and `rf_wdata`. A read is a one-cycle `rf_re` pulse, and the file must return `rf_rdata` for `rf_addr` combinationally in that same cycle.

Top module: `spi_rf_frame`

## Requirements
- R1: The command word is read as follows. Bit 31 is the direction, 1 for write and 0 for read. Bits 30:25 give the read length in words. Bits 24:4 give the 21-bit word address. Bits 3:0 have no effect.
- R2: In a write frame, each complete payload word produces exactly one `rf_we` pulse carrying that word on `rf_wdata`. The first goes to the command address and each later one to the next word address, wrapping modulo 2^21.
- R3: A write frame carries at most 64 payload words. Words past the 64th produce no `rf_we`, and they set `frame_err`. `frame_err` holds until the next frame starts, when it returns to 0.
- R4: In a read frame with length N, MISO carries the words at addresses A, A+1, … A+N-1, MSB first. The first bit is valid at the SCLK rising edge that follows the 32nd command bit.
- R5: MISO is 0 in these cases: while chip select is high, during the command word, during write payload, and for every bit after the N requested read words.
- R6: Raising chip select ends the frame. A partly received word is discarded without any `rf_we`. The next frame starts decoding afresh with its own command word.
- R7: `rf_re` pulses exactly N times in a read frame of length N, never in a write frame, and never in the same cycle as `rf_we`.
- R8: After reset, `spi_miso`, `rf_we`, `rf_re` and `frame_err` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| spi_sclk | input | 1 | SPI serial clock, mode 0 |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master |
| rf_addr | output | 21 | Register-file word address |
| rf_wdata | output | 32 | Register-file write data |
| rf_we | output | 1 | Register-file write strobe, one cycle |
| rf_re | output | 1 | Register-file read strobe, one cycle |
| rf_rdata | input | 32 | Register-file read data, valid in the `rf_re` cycle |
| frame_err | output | 1 | Write payload exceeded the word limit in the current or last frame |

## Verification
Two situations are hard to reach from the ports. The first is the overlong write, because 64 full words must be clocked in before the limit can even be approached. The bench runs one directed frame with 66 payload words, then a short frame to show that the flag clears. The second is the word-boundary handoff on MISO, where the prefetched word must replace the shift register between a rising and a falling SCLK edge. Directed reads that continue past their length are mixed with randomly sized read and write frames at random addresses, one of them placed at the top of the address space, and with frames cut off in the middle of the command word and in the middle of a payload word.

// File: rtl/spi_rf_pkg.sv
package spi_rf_pkg;
  localparam int WORD_W = 32;
  localparam int ADDR_W = 21;
  localparam int LEN_W  = 6;
  localparam int BIT_W  = $clog2(WORD_W);

  typedef struct packed {
    logic              wr;
    logic [LEN_W-1:0]  len;
    logic [ADDR_W-1:0] addr;
    logic [3:0]        unused;
  } cmd_t;
endpackage

// File: rtl/spi_rf_sync.sv
module spi_rf_sync #(
  parameter int         N       = 3,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic [1:0] st;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st <= {2{RST_VAL[i]}};
      else        st <= {st[0], d[i]};
    end
    assign q[i] = st[1];
  end
endmodule

// File: rtl/spi_rf_rx.sv
module spi_rf_rx
  import spi_rf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_act,
  input  logic              sclk_s,
  input  logic              mosi_s,
  output logic              fall,
  output logic              word_vld,
  output logic [WORD_W-1:0] rx_word
);
  logic              sclk_d;
  logic              rise;
  logic [BIT_W-1:0]  bit_q, bit_n;
  logic [WORD_W-1:0] sr_q, sr_n;
  logic              vld_n;

  assign rise = cs_act & sclk_s & ~sclk_d;
  assign fall = cs_act & ~sclk_s & sclk_d;

  always_comb begin
    bit_n = bit_q;
    sr_n  = sr_q;
    vld_n = 1'b0;
    if (!cs_act) begin
      bit_n = '0;
    end else if (rise) begin
      sr_n  = {sr_q[WORD_W-2:0], mosi_s};
      bit_n = bit_q + 1'b1;
      vld_n = (bit_q == BIT_W'(WORD_W - 1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d   <= 1'b0;
      bit_q    <= '0;
      sr_q     <= '0;
      word_vld <= 1'b0;
    end else begin
      sclk_d   <= sclk_s;
      bit_q    <= bit_n;
      sr_q     <= sr_n;
      word_vld <= vld_n;
    end
  end

  assign rx_word = sr_q;

  // R6: a frame end always leaves the bit counter at a word boundary
  a_r6_abort_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> bit_q == '0);
  // R6: a word is only reported once all of its bits have been counted
  a_r6_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    word_vld |-> bit_q == '0);
endmodule

// File: rtl/spi_rf_ctrl.sv
module spi_rf_ctrl
  import spi_rf_pkg::*;
#(
  parameter int MAX_WORDS = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_act,
  input  logic              fall,
  input  logic              word_vld,
  input  logic [WORD_W-1:0] rx_word,
  input  logic [WORD_W-1:0] rf_rdata,
  output logic [ADDR_W-1:0] rf_addr,
  output logic [WORD_W-1:0] rf_wdata,
  output logic              rf_we,
  output logic              rf_re,
  output logic              miso,
  output logic              frame_err
);
  localparam int WCNT_W = $clog2(MAX_WORDS + 1);

  cmd_t              cmd;
  logic              cs_d;
  logic              hdr_q, hdr_n, wr_q, wr_n, err_q, err_n;
  logic              we_q, we_n, re_q, re_n, load_q, load_n;
  logic [LEN_W-1:0]  left_q, left_n;
  logic [ADDR_W-1:0] addr_q, addr_n;
  logic [WCNT_W-1:0] wcnt_q, wcnt_n;
  logic [WORD_W-1:0] wdat_q, wdat_n, tx_q, tx_n, hold_q, hold_n;

  assign cmd = cmd_t'(rx_word);

  always_comb begin
    hdr_n  = hdr_q;  wr_n   = wr_q;   err_n  = err_q;
    left_n = left_q; addr_n = addr_q; wcnt_n = wcnt_q;
    wdat_n = wdat_q; tx_n   = tx_q;   hold_n = hold_q;
    load_n = load_q; we_n   = 1'b0;   re_n   = 1'b0;
    if (!cs_act) begin
      hdr_n  = 1'b0;
      left_n = '0;
      wcnt_n = '0;
      tx_n   = '0;
      hold_n = '0;
      load_n = 1'b0;
    end else begin
      if (!cs_d) err_n = 1'b0;
      if (we_q || re_q) addr_n = addr_q + 1'b1;
      if (re_q) begin
        hold_n = rf_rdata;
        left_n = left_q - 1'b1;
      end
      if (word_vld) begin
        load_n = 1'b1;
        hold_n = '0;
        if (!hdr_q) begin
          hdr_n  = 1'b1;
          wr_n   = cmd.wr;
          addr_n = cmd.addr;
          left_n = cmd.len;
          re_n   = !cmd.wr && (cmd.len != '0);
        end else if (wr_q) begin
          if (wcnt_q < WCNT_W'(MAX_WORDS)) begin
            we_n   = 1'b1;
            wdat_n = rx_word;
            wcnt_n = wcnt_q + 1'b1;
          end else begin
            err_n = 1'b1;
          end
        end else begin
          re_n = (left_q != '0);
        end
      end
      if (fall) begin
        if (load_q) begin
          tx_n   = hold_q;
          load_n = 1'b0;
        end else begin
          tx_n = {tx_q[WORD_W-2:0], 1'b0};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_d <= 1'b0;  hdr_q <= 1'b0; wr_q <= 1'b0; err_q <= 1'b0;
      we_q <= 1'b0;  re_q  <= 1'b0; load_q <= 1'b0;
      left_q <= '0;  addr_q <= '0;  wcnt_q <= '0;
      wdat_q <= '0;  tx_q <= '0;    hold_q <= '0;
    end else begin
      cs_d <= cs_act; hdr_q <= hdr_n; wr_q <= wr_n; err_q <= err_n;
      we_q <= we_n;   re_q  <= re_n;  load_q <= load_n;
      left_q <= left_n; addr_q <= addr_n; wcnt_q <= wcnt_n;
      wdat_q <= wdat_n; tx_q <= tx_n;     hold_q <= hold_n;
    end
  end

  assign rf_addr   = addr_q;
  assign rf_wdata  = wdat_q;
  assign rf_we     = we_q;
  assign rf_re     = re_q;
  assign miso      = tx_q[WORD_W-1];
  assign frame_err = err_q;

  // R7: the two register-file strobes never coincide
  a_r7_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(rf_we && rf_re));
  // R7: reads are only issued inside a decoded read frame
  a_r7_read_frame_only: assert property (@(posedge clk) disable iff (!rst_n)
    rf_re |-> hdr_q && !wr_q);
  // R2: every accepted word moves the address on by one
  a_r2_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |=> rf_addr == $past(rf_addr) + 1'b1);
  // R3: the error flag only rises once the word limit is used up
  a_r3_err_at_limit: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_err) |-> wcnt_q == WCNT_W'(MAX_WORDS));
  // R5: no data leaves while chip select is inactive
  a_r5_miso_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> !miso);
endmodule

// File: rtl/spi_rf_frame.sv
module spi_rf_frame
  import spi_rf_pkg::*;
#(
  parameter int MAX_WORDS = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sclk,
  input  logic              spi_cs_n,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic [ADDR_W-1:0] rf_addr,
  output logic [WORD_W-1:0] rf_wdata,
  output logic              rf_we,
  output logic              rf_re,
  input  logic [WORD_W-1:0] rf_rdata,
  output logic              frame_err
);
  logic [1:0]        rst_sync;
  logic              rst_q_n;
  logic [2:0]        pins_s;
  logic              cs_act, fall, word_vld;
  logic [WORD_W-1:0] rx_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q_n = rst_sync[1];

  spi_rf_sync #(.N(3), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_q_n),
    .d({spi_cs_n, spi_sclk, spi_mosi}), .q(pins_s)
  );
  assign cs_act = ~pins_s[2];

  spi_rf_rx u_rx (
    .clk(clk), .rst_n(rst_q_n), .cs_act(cs_act), .sclk_s(pins_s[1]),
    .mosi_s(pins_s[0]), .fall(fall), .word_vld(word_vld), .rx_word(rx_word)
  );

  spi_rf_ctrl #(.MAX_WORDS(MAX_WORDS)) u_ctrl (
    .clk(clk), .rst_n(rst_q_n), .cs_act(cs_act), .fall(fall),
    .word_vld(word_vld), .rx_word(rx_word), .rf_rdata(rf_rdata),
    .rf_addr(rf_addr), .rf_wdata(rf_wdata), .rf_we(rf_we), .rf_re(rf_re),
    .miso(spi_miso), .frame_err(frame_err)
  );
endmodule

// File: tb/spi_rf_frame_bench.sv
module spi_rf_frame_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic        miso, we, re, err;
  logic [20:0] addr;
  logic [31:0] wdata, rdata;

  int checks = 0, errors = 0;
  int wn = 0, rn = 0;
  logic [20:0] wl_a [0:511];
  logic [31:0] wl_d [0:511];
  logic [31:0] txw [0:71];
  logic [31:0] rxw [0:71];

  always #10 clk = ~clk;

  function automatic logic [31:0] rd_fn(input logic [20:0] a);
    return (32'(a) * 32'h9E3779B1) ^ 32'hC3A5_0F1E;
  endfunction

  function automatic logic [31:0] mk_cmd(input bit w, input int len,
                                         input logic [20:0] a, input logic [3:0] lo);
    return {w, 6'(len), a, lo};
  endfunction

  assign rdata = rd_fn(addr);

  spi_rf_frame u_spi_rf_frame (
    .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n),
    .spi_mosi(mosi), .spi_miso(miso), .rf_addr(addr), .rf_wdata(wdata),
    .rf_we(we), .rf_re(re), .rf_rdata(rdata), .frame_err(err)
  );

  always @(posedge clk) begin
    if (we && wn < 512) begin
      wl_a[wn] <= addr;
      wl_d[wn] <= wdata;
    end
    if (we) wn <= wn + 1;
    if (re) rn <= rn + 1;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic run_frame(input int nbits);
    for (int k = 0; k < 72; k++) rxw[k] = '0;
    cs_n = 1'b0;
    wait_clk(8);
    for (int i = 0; i < nbits; i++) begin
      mosi = txw[i/32][31 - (i % 32)];
      wait_clk(8);
      rxw[i/32][31 - (i % 32)] = miso;
      chk(miso === 1'b0 || (i >= 32), "R5 command bits", 32'(miso), 32'h0);
      sclk = 1'b1;
      wait_clk(8);
      sclk = 1'b0;
    end
    wait_clk(8);
    cs_n = 1'b1;
    wait_clk(16);
    chk(miso === 1'b0, "R5 idle miso", 32'(miso), 32'h0);
  endtask

  task automatic do_write(input logic [20:0] a, input int nw, input int extra,
                          input logic [3:0] lo);
    int w0 = wn;
    int expn = (nw > 64) ? 64 : nw;
    txw[0] = mk_cmd(1'b1, $urandom_range(0, 63), a, lo);
    for (int k = 1; k <= nw; k++) txw[k] = $urandom;
    txw[nw + 1] = $urandom;
    run_frame(32 * (nw + 1) + extra);
    chk(wn - w0 == expn, "R2 R6 write count", 32'(wn - w0), 32'(expn));
    for (int k = 0; k < expn && k < 8; k++) begin
      chk(wl_a[w0 + k] == a + 21'(k), "R1 R2 write address",
          32'(wl_a[w0 + k]), 32'(a + 21'(k)));
      chk(wl_d[w0 + k] == txw[k + 1], "R2 write data", wl_d[w0 + k], txw[k + 1]);
    end
    for (int k = 1; k <= nw; k++)
      chk(rxw[k] == 32'h0, "R5 miso during write", rxw[k], 32'h0);
  endtask

  task automatic do_read(input logic [20:0] a, input int len, input int nw,
                         input logic [3:0] lo);
    int r0 = rn;
    int w0 = wn;
    logic [31:0] e;
    txw[0] = mk_cmd(1'b0, len, a, lo);
    for (int k = 1; k <= nw; k++) txw[k] = $urandom;
    run_frame(32 * (nw + 1));
    chk(rn - r0 == len, "R7 read strobes", 32'(rn - r0), 32'(len));
    chk(wn == w0, "R7 no write in read", 32'(wn - w0), 32'h0);
    for (int k = 0; k < nw; k++) begin
      e = (k < len) ? rd_fn(a + 21'(k)) : 32'h0;
      chk(rxw[k + 1] == e, (k < len) ? "R4 read word" : "R5 read tail",
          rxw[k + 1], e);
    end
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : stim
    void'($urandom(32'd20240611));
    wait_clk(3);
    chk(miso === 1'b0 && we === 1'b0 && re === 1'b0 && err === 1'b0,
        "R8 reset state", {28'h0, miso, we, re, err}, 32'h0);
    rst_n = 1'b1;
    wait_clk(4);
    chk(miso === 1'b0 && we === 1'b0 && re === 1'b0 && err === 1'b0,
        "R8 after release", {28'h0, miso, we, re, err}, 32'h0);

    do_write(21'h0ABCD, 3, 0, 4'hF);          // R1 low bits ignored, R2
    do_read(21'h00100, 3, 6, 4'h5);           // R4 then R5 tail
    do_read(21'h1F000, 0, 2, 4'h0);           // R5 zero length
    do_write(21'h1FFFFF, 2, 0, 4'h0);         // R2 address wrap
    do_write(21'h00200, 66, 0, 4'h0);         // R3 overlong
    chk(err === 1'b1, "R3 error set", 32'(err), 32'h1);
    do_read(21'h00300, 1, 1, 4'h0);
    chk(err === 1'b0, "R3 error cleared", 32'(err), 32'h0);
    do_write(21'h00400, 1, 20, 4'h0);         // R6 abort mid word
    txw[0] = 32'hFFFF_FFFF;
    run_frame(20);                            // R6 abort mid command
    do_read(21'h00500, 2, 2, 4'h3);           // R6 fresh decode after abort
    chk(err === 1'b0, "R3 no error on short frames", 32'(err), 32'h0);

    for (int f = 0; f < 8; f++) begin
      logic [20:0] a = 21'($urandom);
      int len = $urandom_range(0, 5);
      if ($urandom_range(0, 1) == 1)
        do_write(a, $urandom_range(1, 6), 0, 4'($urandom));
      else
        do_read(a, len, len + $urandom_range(0, 1), 4'($urandom));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule